// File: doc/BRIEF.md
# Tri-state PWM input classifier

This block turns a digitised voltage on a PWM control pin into one of three logic states: HIGH, LOW or TRI. TRI means the mid level that appears when the driving controller lets the pin float. One converter code arrives on every clock. Four threshold codes set the decision points. Hysteresis between them keeps noise near a boundary from toggling the result.

A level in the mid band is not reported as TRI at once. It must stay in that band for a programmable number of consecutive samples. Until then the output keeps its last HIGH or LOW value. A small write port loads the thresholds and the hold-off length. The outputs are the decoded state and a one-cycle strobe that marks every change of that state.

Top module: `pwm_tri_decoder`

## Requirements
- R1: After reset `state_o` is TRI (2'b10) and `changed_o` is 0. The registers reset to these defaults: upper threshold 757, lower threshold 184, mid-from-low threshold 235, mid-from-high threshold 685, hold-off 7. A mid-level input held from reset keeps TRI with no strobe.
- R2: A sample strictly above the upper threshold (address 0) gives HIGH (2'b01) after the next clock edge, whatever the prior state. A sample equal to the threshold does not.
- R3: A sample strictly below the lower threshold (address 1) gives LOW (2'b00) after the next clock edge, whatever the prior state. A sample equal to the threshold does not.
- R4: From the low zone, a sample strictly above the mid-from-low threshold (address 2), and not above the upper threshold, moves the tracker into the mid zone. A sample at or below address 2 keeps the low zone.
- R5: From the high zone, a sample strictly below the mid-from-high threshold (address 3), and not below the lower threshold, moves the tracker into the mid zone. A sample at or above address 3 keeps the high zone.
- R6: TRI is reported after the edge that takes the N-th consecutive mid-zone sample, where N is the hold-off value (address 4). A value of 0 acts as 1. Until then the previous HIGH or LOW stays on `state_o`.
- R7: Leaving the mid zone before the hold-off expires clears the run. A later entry needs a full fresh run of N samples.
- R8: While in the mid zone, any sample from the lower threshold up to the upper threshold, both included, keeps the mid zone and its run.
- R9: `changed_o` is 1 for exactly the cycle after any edge at which `state_o` took a new value, and 0 otherwise.
- R10: A write with `cfg_we`=1 loads `cfg_wdata` into the register selected by `cfg_addr`. Addresses 0 to 3 are the thresholds above and 4 is the hold-off. The new value applies to samples taken at later edges. Addresses 5 to 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one level sample per rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | 3 | Configuration register select |
| cfg_wdata | input | 10 | Configuration write data (hold-off uses the low 8 bits) |
| level_code | input | 10 | Digitised pin level |
| state_o | output | 2 | Decoded state: 00 LOW, 01 HIGH, 10 TRI |
| changed_o | output | 1 | One-cycle strobe on every state change |

## Verification
On every cycle the assertions check the following:
- The outer thresholds force HIGH or LOW one edge later.
- The hysteresis bands hold the zone they start from.
- A new TRI only appears while the tracker is in the mid zone.
- The strobe matches a change of the state output.
- The state right after reset is TRI.

Only the bench scenarios can show the following:
- The exact count of the hold-off, including the value 0 and the default of 7.
- That an interrupted run is cleared.
- Equality at each threshold.
- The default threshold codes.
- That writes to unused addresses leave the behaviour unchanged.

// File: rtl/pwm_tri_pkg.sv
package pwm_tri_pkg;

    typedef enum logic [1:0] {
        ST_LOW  = 2'b00,
        ST_HIGH = 2'b01,
        ST_TRI  = 2'b10
    } pin_state_t;

    typedef enum logic [1:0] {
        ZN_LOW  = 2'b00,
        ZN_MID  = 2'b01,
        ZN_HIGH = 2'b10
    } zone_t;

    // comparator results for one sample
    typedef struct packed {
        logic above_up;
        logic below_dn;
        logic above_mid_lo;
        logic below_mid_hi;
    } cmp_t;

    localparam int NUM_THR    = 4;
    localparam int IDX_UP     = 0;
    localparam int IDX_DN     = 1;
    localparam int IDX_MID_LO = 2;
    localparam int IDX_MID_HI = 3;
    localparam int ADDR_HOLD  = 4;

    function automatic int max_int(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic int thr_default_mv(input int idx);
        case (idx)
            IDX_UP:     return 3700;
            IDX_DN:     return 900;
            IDX_MID_LO: return 1150;
            default:    return 3350;
        endcase
    endfunction

    function automatic int mv_to_code(input int mv, input int full_mv, input int code_w);
        return (mv * ((1 << code_w) - 1)) / full_mv;
    endfunction

    function automatic zone_t next_zone(input zone_t cur, input cmp_t c);
        zone_t nz;
        nz = cur;
        if (c.above_up)
            nz = ZN_HIGH;
        else if (c.below_dn)
            nz = ZN_LOW;
        else if (cur == ZN_LOW && c.above_mid_lo)
            nz = ZN_MID;
        else if (cur == ZN_HIGH && c.below_mid_hi)
            nz = ZN_MID;
        return nz;
    endfunction

endpackage

// File: rtl/pwm_tri_cfg.sv
module pwm_tri_cfg
    import pwm_tri_pkg::*;
#(
    parameter int CODE_W   = 10,
    parameter int HOLD_W   = 8,
    parameter int FULL_MV  = 5000,
    parameter int HOLD_DEF = 7
) (
    input  logic                                  clk,
    input  logic                                  rst,
    input  logic                                  we,
    input  logic [2:0]                            addr,
    input  logic [max_int(CODE_W, HOLD_W)-1:0]    wdata,
    output logic [CODE_W-1:0]                     thr_o [NUM_THR],
    output logic [HOLD_W-1:0]                     hold_o
);

    for (genvar i = 0; i < NUM_THR; i++) begin : g_thr
        localparam logic [CODE_W-1:0] RST_VAL =
            CODE_W'(mv_to_code(thr_default_mv(i), FULL_MV, CODE_W));
        always_ff @(posedge clk) begin
            if (rst)
                thr_o[i] <= RST_VAL;
            else if (we && addr == 3'(i))
                thr_o[i] <= wdata[CODE_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            hold_o <= HOLD_W'(HOLD_DEF);
        else if (we && addr == 3'(ADDR_HOLD))
            hold_o <= wdata[HOLD_W-1:0];
    end

endmodule

// File: rtl/pwm_tri_zone.sv
module pwm_tri_zone
    import pwm_tri_pkg::*;
#(
    parameter int CODE_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CODE_W-1:0] level,
    input  logic [CODE_W-1:0] thr [NUM_THR],
    output zone_t             zone_q,
    output zone_t             zone_d
);

    cmp_t cmp;

    always_comb begin
        cmp.above_up     = level > thr[IDX_UP];
        cmp.below_dn     = level < thr[IDX_DN];
        cmp.above_mid_lo = level > thr[IDX_MID_LO];
        cmp.below_mid_hi = level < thr[IDX_MID_HI];
        zone_d           = next_zone(zone_q, cmp);
    end

    always_ff @(posedge clk) begin
        if (rst)
            zone_q <= ZN_MID;
        else
            zone_q <= zone_d;
    end

endmodule

// File: rtl/pwm_tri_holdoff.sv
module pwm_tri_holdoff
    import pwm_tri_pkg::*;
#(
    parameter int HOLD_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  zone_t             zone_d,
    input  logic [HOLD_W-1:0] hold,
    output pin_state_t        state_q,
    output logic              changed_q
);

    localparam logic [HOLD_W-1:0] CNT_MAX = '1;

    logic [HOLD_W-1:0] run_q;
    logic [HOLD_W-1:0] run_d;
    pin_state_t        state_d;

    always_comb begin
        if (zone_d != ZN_MID)
            run_d = '0;
        else if (run_q == CNT_MAX)
            run_d = run_q;
        else
            run_d = run_q + 1'b1;

        case (zone_d)
            ZN_HIGH: state_d = ST_HIGH;
            ZN_LOW:  state_d = ST_LOW;
            default: state_d = (run_d >= hold) ? ST_TRI : state_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q     <= '0;
            state_q   <= ST_TRI;
            changed_q <= 1'b0;
        end else begin
            run_q     <= run_d;
            state_q   <= state_d;
            changed_q <= (state_d != state_q);
        end
    end

endmodule

// File: rtl/pwm_tri_decoder.sv
module pwm_tri_decoder
    import pwm_tri_pkg::*;
#(
    parameter int CODE_W   = 10,
    parameter int HOLD_W   = 8,
    parameter int FULL_MV  = 5000,
    parameter int HOLD_DEF = 7
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               cfg_we,
    input  logic [2:0]                         cfg_addr,
    input  logic [max_int(CODE_W, HOLD_W)-1:0] cfg_wdata,
    input  logic [CODE_W-1:0]                  level_code,
    output logic [1:0]                         state_o,
    output logic                               changed_o
);

    logic [CODE_W-1:0] thr_w [NUM_THR];
    logic [HOLD_W-1:0] hold_w;
    zone_t             zone_q;
    zone_t             zone_d;
    pin_state_t        state_w;

    pwm_tri_cfg #(
        .CODE_W(CODE_W), .HOLD_W(HOLD_W), .FULL_MV(FULL_MV), .HOLD_DEF(HOLD_DEF)
    ) u_cfg (
        .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
        .thr_o(thr_w), .hold_o(hold_w)
    );

    pwm_tri_zone #(.CODE_W(CODE_W)) u_zone (
        .clk(clk), .rst(rst), .level(level_code), .thr(thr_w),
        .zone_q(zone_q), .zone_d(zone_d)
    );

    pwm_tri_holdoff #(.HOLD_W(HOLD_W)) u_hold (
        .clk(clk), .rst(rst), .zone_d(zone_d), .hold(hold_w),
        .state_q(state_w), .changed_q(changed_o)
    );

    assign state_o = state_w;

endmodule

// File: rtl/pwm_tri_decoder_chk.sv
module pwm_tri_decoder_chk
    import pwm_tri_pkg::*;
#(
    parameter int CODE_W = 10
) (
    input logic              clk,
    input logic              rst,
    input logic [CODE_W-1:0] level_code,
    input logic [1:0]        state_o,
    input logic              changed_o,
    input logic [CODE_W-1:0] thr_up,
    input logic [CODE_W-1:0] thr_dn,
    input logic [CODE_W-1:0] thr_mid_lo,
    input logic [CODE_W-1:0] thr_mid_hi,
    input zone_t             zone
);

    AST_RESET_TRI: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (state_o == ST_TRI && !changed_o)); // R1

    AST_ABOVE_UP_HIGH: assert property (@(posedge clk) disable iff (rst)
        (level_code > thr_up) |=> (state_o == ST_HIGH)); // R2

    AST_BELOW_DN_LOW: assert property (@(posedge clk) disable iff (rst)
        (level_code < thr_dn && level_code <= thr_up) |=> (state_o == ST_LOW)); // R3

    AST_LOW_BAND_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (zone == ZN_LOW && level_code >= thr_dn && level_code <= thr_mid_lo
         && level_code <= thr_up) |=> (zone == ZN_LOW)); // R4

    AST_HIGH_BAND_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (zone == ZN_HIGH && level_code >= thr_mid_hi && level_code <= thr_up
         && level_code >= thr_dn) |=> (zone == ZN_HIGH)); // R5

    AST_TRI_ONLY_IN_MID: assert property (@(posedge clk) disable iff (rst)
        (state_o == ST_TRI && $past(state_o) != ST_TRI) |-> (zone == ZN_MID)); // R6

    AST_STROBE_ON_CHANGE: assert property (@(posedge clk) disable iff (rst)
        !$fell(rst) |-> (changed_o == (state_o != $past(state_o)))); // R9

endmodule

bind pwm_tri_decoder pwm_tri_decoder_chk #(.CODE_W(CODE_W)) u_chk (
    .clk(clk), .rst(rst), .level_code(level_code), .state_o(state_o),
    .changed_o(changed_o),
    .thr_up(thr_w[pwm_tri_pkg::IDX_UP]), .thr_dn(thr_w[pwm_tri_pkg::IDX_DN]),
    .thr_mid_lo(thr_w[pwm_tri_pkg::IDX_MID_LO]),
    .thr_mid_hi(thr_w[pwm_tri_pkg::IDX_MID_HI]),
    .zone(zone_q)
);

// File: tb/pwm_tri_decoder_bench.sv
`timescale 1ns/1ps
module pwm_tri_decoder_bench;

    localparam logic [1:0] S_LOW  = 2'b00;
    localparam logic [1:0] S_HIGH = 2'b01;
    localparam logic [1:0] S_TRI  = 2'b10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_we = 1'b0;
    logic [2:0] cfg_addr = '0;
    logic [9:0] cfg_wdata = '0;
    logic [9:0] level_code = 10'd460;
    logic [1:0] state_o;
    logic       changed_o;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    pwm_tri_decoder u_pwm_tri_decoder (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .level_code(level_code),
        .state_o(state_o), .changed_o(changed_o)
    );

    // {code, expected state, expected strobe}; hold-off 3, default thresholds
    localparam int NVEC = 22;
    localparam logic [12:0] VEC [NVEC] = '{
        {10'd100,  S_LOW,  1'b1},  // R3 from TRI
        {10'd200,  S_LOW,  1'b0},  // R4 below mid-from-low
        {10'd235,  S_LOW,  1'b0},  // R4 equal stays low
        {10'd236,  S_LOW,  1'b0},  // R4 enter mid, run 1
        {10'd500,  S_LOW,  1'b0},  // run 2
        {10'd100,  S_LOW,  1'b0},  // R7 run cleared
        {10'd300,  S_LOW,  1'b0},  // run 1
        {10'd300,  S_LOW,  1'b0},  // run 2
        {10'd300,  S_TRI,  1'b1},  // R6 run 3
        {10'd300,  S_TRI,  1'b0},
        {10'd757,  S_TRI,  1'b0},  // R2 equal is not high, R8
        {10'd758,  S_HIGH, 1'b1},  // R2
        {10'd700,  S_HIGH, 1'b0},  // R5 band
        {10'd685,  S_HIGH, 1'b0},  // R5 equal stays high
        {10'd684,  S_HIGH, 1'b0},  // R5 enter mid, run 1
        {10'd758,  S_HIGH, 1'b0},  // R7 run cleared
        {10'd600,  S_HIGH, 1'b0},  // run 1
        {10'd200,  S_HIGH, 1'b0},  // R8 still mid, run 2
        {10'd184,  S_TRI,  1'b1},  // R8 equal lower, run 3
        {10'd183,  S_LOW,  1'b1},  // R3
        {10'd1023, S_HIGH, 1'b1},  // R2 low to high direct
        {10'd0,    S_LOW,  1'b1}   // R3 high to low direct
    };

    task automatic check(input logic [1:0] es, input logic ec, input string req);
        n_chk++;
        if (state_o !== es || changed_o !== ec) begin
            n_bad++;
            $display("FAIL %s: state=%b changed=%b expected state=%b changed=%b",
                     req, state_o, changed_o, es, ec);
        end
    endtask

    task automatic step(input logic [9:0] code);
        @(negedge clk);
        level_code = code;
        @(posedge clk);
        #2;
    endtask

    task automatic cfg_write(input logic [2:0] a, input logic [9:0] d);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_addr = a;
        cfg_wdata = d;
        @(posedge clk);
        #2;
        cfg_we = 1'b0;
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #4_000_000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: state=%b changed=%b expected run to end", state_o, changed_o);
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        check(S_TRI, 1'b0, "R1 reset state");
        @(negedge clk);
        rst = 1'b0;
        step(10'd460);
        check(S_TRI, 1'b0, "R1 floating after reset");
        step(10'd460);
        check(S_TRI, 1'b0, "R1 floating after reset");

        step(10'd100);
        check(S_LOW, 1'b1, "R3 low from tri");
        for (int i = 1; i <= 6; i++) begin
            step(10'd460);
            check(S_LOW, 1'b0, "R6 default hold-off pending");
        end
        step(10'd460);
        check(S_TRI, 1'b1, "R6 default hold-off 7 expires");
        step(10'd460);
        check(S_TRI, 1'b0, "R9 strobe lasts one cycle");

        cfg_write(3'd4, 10'd3);
        check(S_TRI, 1'b0, "R10 hold-off write");
        for (int i = 0; i < NVEC; i++) begin
            step(VEC[i][12:3]);
            check(VEC[i][2:1], VEC[i][0], $sformatf("R4/R5/R7/R8/R9 table row %0d", i));
        end

        cfg_write(3'd5, 10'd1000);
        cfg_write(3'd6, 10'd1000);
        cfg_write(3'd7, 10'd1000);
        step(10'd0);
        check(S_LOW, 1'b0, "R10 unused addresses");
        step(10'd300);
        check(S_LOW, 1'b0, "R10 unused addresses");
        step(10'd300);
        check(S_LOW, 1'b0, "R10 unused addresses");
        step(10'd300);
        check(S_TRI, 1'b1, "R10 unused addresses leave hold-off");

        cfg_write(3'd0, 10'd500);
        step(10'd501);
        check(S_HIGH, 1'b1, "R10 new upper threshold R2");

        cfg_write(3'd4, 10'd0);
        step(10'd0);
        check(S_LOW, 1'b1, "R3 before zero hold-off");
        step(10'd300);
        check(S_TRI, 1'b1, "R6 zero hold-off acts as one");

        finish_run();
    end

endmodule